// File: doc/BRIEF.md
# DVFS Operating Point Sequencer

This block moves a processor subsystem from one discrete voltage/frequency operating point to another in an order that is always safe for the logic. A separate policy block sends a target level. The sequencer looks up the supply code, the CPU clock select and the bus clock divide for that level in a table built from parameters. It stops the core clock, applies the two changes in the order the direction requires, waits for the supply to settle, and then lets the clock run again.

Going up, the supply is raised first and the faster clock is selected only after the rail has settled. Going down, the slower clock is selected first and the supply is lowered afterwards. The settle wait is a down-counter. It is loaded with the absolute difference between the old and new supply codes multiplied by a per-code cycle count, and the block also waits for the supply to report that it has settled. A request for the level already in use completes at once, with no clock pause. The defaults give three levels, with supply codes in 10 mV units: 110 (1.1 V, 100 MHz), 120, and 130 (1.3 V, 200 MHz).

Top module: `dvfs_opp_sequencer`

## Requirements
- R1: After reset, the outputs show the reset level (default level 0): supply code 110, clock select 0, bus divide 0, pause, busy and done low, and current level 0.
- R2: Level i maps to supply code VCODE_BASE + i*VCODE_STEP (defaults 110, 120, 130). The clock select is the binary level number, or bit i set when the one-hot variant is chosen. The bus divide code is 1 (bus at half the CPU clock) for levels at or above BUS_HALF_FROM (default 2), and 0 below it.
- R3: On a move to a higher level, the supply code changes on the second edge after the request is accepted. The clock select and bus divide change only after the settle wait has ended.
- R4: On a move to a lower level, the clock select and bus divide change on the second edge after acceptance, and the supply code changes on the next edge.
- R5: The supply code, the clock select and the bus divide change only on an edge where the clock pause was already high and stays high.
- R6: After the supply code changes, the next step waits until |old code - new code| * STEP_CYCLES cycles have passed and vdd_settled is high. With vdd_settled held high, done appears delta*STEP_CYCLES + 4 edges after the accepting edge.
- R7: busy is high from the accepting edge until the final step. On that step busy falls, done pulses high for exactly one cycle, and the current level takes the new value.
- R8: A request that arrives while busy is high is ignored; the transition finishes at the level first accepted.
- R9: A request for the current level raises done on the next edge, and pause and busy stay low.
- R10: A request for a level number at or above NUM_LEVELS (3 with the defaults) is ignored: no busy, no done, and no output change.
- R11: The clock pause rises on the accepting edge, and on that edge neither the supply code nor the clock select changes. The pause falls together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Target-level request strobe |
| req_level | input | LVL_W | Requested level number |
| vdd_settled | input | 1 | Supply reports the rail is at its code |
| vdd_code | output | VCODE_W | Supply voltage code |
| cpu_clk_sel | output | CSEL_W | CPU clock source select |
| bus_clk_div | output | 1 | Bus clock at half the CPU clock when 1 |
| clk_pause | output | 1 | Core clock held while high |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_level | output | LVL_W | Level currently in force |

## Verification
The main function is tried with an upward move spanning two levels and a downward move of one level. Comparing the cycles in which the supply code and the clock select change tells the two orderings apart, and the completion cycle tells the delta-scaled settle times apart. An upward move with vdd_settled held low past the counter shows that both conditions gate progress. A second request during a long downward move, a same-level request and an out-of-range level separate the ignore paths from the normal one.

// File: rtl/dvfs_seq_pkg.sv
`timescale 1ns/1ps
package dvfs_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ORDER,
      SQ_VLOAD,
      SQ_SETTLE,
      SQ_FREQ,
      SQ_RESUME
   } sq_state_e;

endpackage

// File: rtl/dvfs_opp_table.sv
`timescale 1ns/1ps
module dvfs_opp_table #(
   parameter int NUM_LEVELS    = 3,
   parameter int LVL_W         = 2,
   parameter int VCODE_W       = 8,
   parameter int VCODE_BASE    = 110,
   parameter int VCODE_STEP    = 10,
   parameter int CSEL_ONEHOT   = 0,
   parameter int CSEL_W        = 2,
   parameter int BUS_HALF_FROM = 2
) (
   input  logic [LVL_W-1:0]   lvl,
   output logic [VCODE_W-1:0] vcode,
   output logic [CSEL_W-1:0]  csel,
   output logic               bus_div
);

   logic [VCODE_W-1:0] vtab [NUM_LEVELS];
   logic               btab [NUM_LEVELS];

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_entry
      assign vtab[g] = VCODE_W'(VCODE_BASE + g * VCODE_STEP);
      assign btab[g] = (g >= BUS_HALF_FROM);
   end

   always_comb begin
      vcode   = vtab[0];
      bus_div = btab[0];
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (lvl == LVL_W'(i)) begin
            vcode   = vtab[i];
            bus_div = btab[i];
         end
      end
   end

   if (CSEL_ONEHOT != 0) begin : g_onehot
      always_comb begin
         csel = '0;
         for (int i = 0; i < NUM_LEVELS; i++) begin
            if (lvl == LVL_W'(i)) csel[i] = 1'b1;
         end
      end
   end else begin : g_binary
      assign csel = CSEL_W'(lvl);
   end

endmodule

// File: rtl/dvfs_settle_timer.sv
`timescale 1ns/1ps
module dvfs_settle_timer #(
   parameter int DELTA_W     = 8,
   parameter int STEP_CYCLES = 2,
   parameter int TMR_W       = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DELTA_W-1:0] delta,
   output logic               expired
);

   localparam bit IS_POW2 = ((STEP_CYCLES & (STEP_CYCLES - 1)) == 0);
   localparam int SHIFT   = $clog2(STEP_CYCLES);

   logic [TMR_W-1:0] load_val;
   logic [TMR_W-1:0] cnt;

   if (IS_POW2) begin : g_shift
      assign load_val = TMR_W'(32'(delta) << SHIFT);
   end else begin : g_mult
      assign load_val = TMR_W'(32'(delta) * STEP_CYCLES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - TMR_W'(1);
      end
   end

   assign expired = (cnt == '0);

   assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

   assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - TMR_W'(1)));

endmodule

// File: rtl/dvfs_seq_ctrl.sv
`timescale 1ns/1ps
module dvfs_seq_ctrl
   import dvfs_seq_pkg::*;
#(
   parameter int NUM_LEVELS  = 3,
   parameter int LVL_W       = 2,
   parameter int VCODE_W     = 8,
   parameter int CSEL_W      = 2,
   parameter int RESET_LEVEL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [LVL_W-1:0]   req_level,
   input  logic               vdd_settled,
   input  logic [VCODE_W-1:0] tgt_vcode,
   input  logic [CSEL_W-1:0]  tgt_csel,
   input  logic               tgt_bus_div,
   input  logic [VCODE_W-1:0] rst_vcode,
   input  logic [CSEL_W-1:0]  rst_csel,
   input  logic               rst_bus_div,
   input  logic               tmr_expired,
   output logic               tmr_load,
   output logic [VCODE_W-1:0] tmr_delta,
   output logic [LVL_W-1:0]   tgt_level,
   output logic [VCODE_W-1:0] vcode,
   output logic [CSEL_W-1:0]  csel,
   output logic               bus_div,
   output logic               clk_pause,
   output logic               busy,
   output logic               done,
   output logic [LVL_W-1:0]   cur_level
);

   localparam logic [LVL_W:0]   LVL_CNT = (LVL_W + 1)'(NUM_LEVELS);
   localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(RESET_LEVEL);

   sq_state_e          state_q;
   logic [LVL_W-1:0]   cur_q, tgt_q;
   logic [VCODE_W-1:0] vcode_q;
   logic [CSEL_W-1:0]  csel_q;
   logic               bdiv_q, pause_q, busy_q, done_q;
   logic               in_range, going_up;

   assign in_range = ({1'b0, req_level} < LVL_CNT);
   assign going_up = (tgt_q > cur_q);

   assign tmr_load  = ((state_q == SQ_ORDER) && going_up) || (state_q == SQ_VLOAD);
   assign tmr_delta = (tgt_vcode >= vcode_q) ? (tgt_vcode - vcode_q) : (vcode_q - tgt_vcode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cur_q   <= LVL_RST;
         tgt_q   <= LVL_RST;
         vcode_q <= rst_vcode;
         csel_q  <= rst_csel;
         bdiv_q  <= rst_bus_div;
         pause_q <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               done_q <= 1'b0;
               if (req_valid && in_range) begin
                  if (req_level == cur_q) begin
                     done_q <= 1'b1;
                  end else begin
                     tgt_q   <= req_level;
                     pause_q <= 1'b1;
                     busy_q  <= 1'b1;
                     state_q <= SQ_ORDER;
                  end
               end
            end
            SQ_ORDER: begin
               if (going_up) begin
                  vcode_q <= tgt_vcode;
                  state_q <= SQ_SETTLE;
               end else begin
                  csel_q  <= tgt_csel;
                  bdiv_q  <= tgt_bus_div;
                  state_q <= SQ_VLOAD;
               end
            end
            SQ_VLOAD: begin
               vcode_q <= tgt_vcode;
               state_q <= SQ_SETTLE;
            end
            SQ_SETTLE: begin
               if (tmr_expired && vdd_settled) begin
                  state_q <= going_up ? SQ_FREQ : SQ_RESUME;
               end
            end
            SQ_FREQ: begin
               csel_q  <= tgt_csel;
               bdiv_q  <= tgt_bus_div;
               state_q <= SQ_RESUME;
            end
            SQ_RESUME: begin
               pause_q <= 1'b0;
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               cur_q   <= tgt_q;
               state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign tgt_level = tgt_q;
   assign vcode     = vcode_q;
   assign csel      = csel_q;
   assign bus_div   = bdiv_q;
   assign clk_pause = pause_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign cur_level = cur_q;

   assert_up_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(csel_q) && going_up) |-> (vcode_q == tgt_vcode));

   assert_down_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(vcode_q) && !going_up) |-> (csel_q == tgt_csel));

   assert_csel_paused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(csel_q) |-> (pause_q && $past(pause_q)));

   assert_vcode_paused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vcode_q) |-> (pause_q && $past(pause_q)));

   assert_bus_paused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bdiv_q) |-> (pause_q && $past(pause_q)));

   assert_settle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_SETTLE && !(tmr_expired && vdd_settled)) |=>
         ($stable(vcode_q) && $stable(csel_q) && pause_q));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   assert_busy_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);

   assert_hold_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(tgt_q));

   assert_same_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && req_valid && req_level == cur_q) |=> (done_q && !pause_q && !busy_q));

   assert_out_of_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && req_valid && !in_range) |=> (!busy_q && !done_q));

   assert_enter_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause_q) |-> ($stable(vcode_q) && $stable(csel_q)));

   assert_pause_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pause_q) |-> done_q);

endmodule

// File: rtl/dvfs_opp_sequencer.sv
`timescale 1ns/1ps
module dvfs_opp_sequencer #(
   parameter int NUM_LEVELS    = 3,
   parameter int VCODE_W       = 8,
   parameter int VCODE_BASE    = 110,
   parameter int VCODE_STEP    = 10,
   parameter int STEP_CYCLES   = 2,
   parameter int CSEL_ONEHOT   = 0,
   parameter int BUS_HALF_FROM = 2,
   parameter int RESET_LEVEL   = 0,
   localparam int LVL_W        = $clog2(NUM_LEVELS),
   localparam int CSEL_W       = (CSEL_ONEHOT != 0) ? NUM_LEVELS : LVL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [LVL_W-1:0]   req_level,
   input  logic               vdd_settled,
   output logic [VCODE_W-1:0] vdd_code,
   output logic [CSEL_W-1:0]  cpu_clk_sel,
   output logic               bus_clk_div,
   output logic               clk_pause,
   output logic               busy,
   output logic               done,
   output logic [LVL_W-1:0]   cur_level
);

   localparam int VSPAN = VCODE_STEP * (NUM_LEVELS - 1);
   localparam int TMR_W = $clog2(VSPAN * STEP_CYCLES + 1);

   if (NUM_LEVELS < 2) begin : g_chk_levels
      $error("sequencer needs at least two operating levels");
   end
   if (VCODE_STEP < 1) begin : g_chk_step
      $error("supply code must rise with level");
   end
   if (STEP_CYCLES < 1) begin : g_chk_cycles
      $error("per-code settle cycles must be positive");
   end
   if (VCODE_BASE + VSPAN >= (1 << VCODE_W)) begin : g_chk_vwidth
      $error("supply code table exceeds VCODE_W");
   end
   if (RESET_LEVEL < 0 || RESET_LEVEL >= NUM_LEVELS) begin : g_chk_reset
      $error("reset level outside the table");
   end

   logic [LVL_W-1:0]   tgt_level;
   logic [VCODE_W-1:0] tgt_vcode, rst_vcode, tmr_delta;
   logic [CSEL_W-1:0]  tgt_csel, rst_csel;
   logic               tgt_bus_div, rst_bus_div;
   logic               tmr_load, tmr_expired;

   dvfs_opp_table #(
      .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VCODE_W(VCODE_W),
      .VCODE_BASE(VCODE_BASE), .VCODE_STEP(VCODE_STEP),
      .CSEL_ONEHOT(CSEL_ONEHOT), .CSEL_W(CSEL_W), .BUS_HALF_FROM(BUS_HALF_FROM)
   ) u_tgt_tbl (
      .lvl(tgt_level), .vcode(tgt_vcode), .csel(tgt_csel), .bus_div(tgt_bus_div)
   );

   dvfs_opp_table #(
      .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VCODE_W(VCODE_W),
      .VCODE_BASE(VCODE_BASE), .VCODE_STEP(VCODE_STEP),
      .CSEL_ONEHOT(CSEL_ONEHOT), .CSEL_W(CSEL_W), .BUS_HALF_FROM(BUS_HALF_FROM)
   ) u_rst_tbl (
      .lvl(LVL_W'(RESET_LEVEL)), .vcode(rst_vcode), .csel(rst_csel), .bus_div(rst_bus_div)
   );

   dvfs_settle_timer #(
      .DELTA_W(VCODE_W), .STEP_CYCLES(STEP_CYCLES), .TMR_W(TMR_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .delta(tmr_delta), .expired(tmr_expired)
   );

   dvfs_seq_ctrl #(
      .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VCODE_W(VCODE_W),
      .CSEL_W(CSEL_W), .RESET_LEVEL(RESET_LEVEL)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_level(req_level), .vdd_settled(vdd_settled),
      .tgt_vcode(tgt_vcode), .tgt_csel(tgt_csel), .tgt_bus_div(tgt_bus_div),
      .rst_vcode(rst_vcode), .rst_csel(rst_csel), .rst_bus_div(rst_bus_div),
      .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_delta(tmr_delta),
      .tgt_level(tgt_level),
      .vcode(vdd_code), .csel(cpu_clk_sel), .bus_div(bus_clk_div),
      .clk_pause(clk_pause), .busy(busy), .done(done), .cur_level(cur_level)
   );

endmodule

// File: tb/tb_dvfs_opp_sequencer.sv
`timescale 1ns/1ps
module tb_dvfs_opp_sequencer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_level = 2'd0;
   logic       vdd_settled = 1'b1;
   logic [7:0] vdd_code;
   logic [1:0] cpu_clk_sel;
   logic       bus_clk_div, clk_pause, busy, done;
   logic [1:0] cur_level;

   always #2 clk = ~clk;

   dvfs_opp_sequencer dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
      .vdd_settled(vdd_settled), .vdd_code(vdd_code), .cpu_clk_sel(cpu_clk_sel),
      .bus_clk_div(bus_clk_div), .clk_pause(clk_pause), .busy(busy), .done(done),
      .cur_level(cur_level)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    over = 1'b0;

   // reference model state
   int  m_cur, m_tgt, m_vc, m_cl, m_wait;
   bit  m_pause, m_busy, m_done;
   byte m_q[$];

   function automatic int lvl_code(int l);
      return 110 + 10 * l;
   endfunction

   task automatic check(string rq, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cur = 0; m_tgt = 0; m_vc = lvl_code(0); m_cl = 0; m_wait = 0;
         m_pause = 0; m_busy = 0; m_done = 0;
         m_q.delete();
      end else begin
         m_done = 0;
         if (m_busy) begin
            case (m_q[0])
               "V": begin
                  m_wait = (lvl_code(m_tgt) > m_vc) ? (lvl_code(m_tgt) - m_vc) * 2
                                                    : (m_vc - lvl_code(m_tgt)) * 2;
                  m_vc = lvl_code(m_tgt);
                  void'(m_q.pop_front());
               end
               "W": begin
                  if (m_wait > 0) m_wait--;
                  else if (vdd_settled) void'(m_q.pop_front());
               end
               "F": begin
                  m_cl = m_tgt;
                  void'(m_q.pop_front());
               end
               default: begin
                  m_busy = 0; m_pause = 0; m_done = 1; m_cur = m_tgt;
                  void'(m_q.pop_front());
               end
            endcase
         end else if (req_valid && int'(req_level) < 3) begin
            if (int'(req_level) == m_cur) begin
               m_done = 1;
            end else begin
               m_tgt = int'(req_level);
               m_busy = 1; m_pause = 1;
               if (m_tgt > m_cur) begin
                  m_q.push_back("V"); m_q.push_back("W"); m_q.push_back("F"); m_q.push_back("E");
               end else begin
                  m_q.push_back("F"); m_q.push_back("V"); m_q.push_back("W"); m_q.push_back("E");
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !over) begin
         n_cmp++;
         if (int'(vdd_code) != m_vc || int'(cpu_clk_sel) != m_cl ||
             bus_clk_div != (m_cl >= 2) || clk_pause != m_pause || busy != m_busy ||
             done != m_done || int'(cur_level) != m_cur) begin
            n_bad++;
            $display("FAIL %s per-cycle: actual v%0d s%0d d%0d p%0d b%0d dn%0d c%0d expected v%0d s%0d d%0d p%0d b%0d dn%0d c%0d",
                     tag, vdd_code, cpu_clk_sel, bus_clk_div, clk_pause, busy, done, cur_level,
                     m_vc, m_cl, (m_cl >= 2), m_pause, m_busy, m_done, m_cur);
         end
      end
   end

   // Issue one request at a negedge; k counts negedges after the accepting edge.
   task automatic run_req(input int lvl, input int poke, input int slow_until, input string rq,
                          output int k_done, output int k_v, output int k_c);
      int   k;
      int   pv, pc;
      logic pp;
      bit   moving;
      moving = (lvl != int'(cur_level));
      pv = int'(vdd_code); pc = int'(cpu_clk_sel); pp = clk_pause;
      tag = rq;
      if (slow_until > 0) vdd_settled = 1'b0;
      req_valid = 1'b1; req_level = 2'(lvl);
      @(negedge clk);
      req_valid = 1'b0;
      k = 1; k_done = -1; k_v = -1; k_c = -1;
      while (k < 400) begin
         if (k == 1 && moving) begin
            check("R11", clk_pause, 1, "pause after accept");
            check("R11", int'(vdd_code), pv, "supply unchanged on accept");
            check("R11", int'(cpu_clk_sel), pc, "clock unchanged on accept");
         end
         if (int'(vdd_code) != pv) begin
            if (k_v < 0) k_v = k;
            check("R5", int'(clk_pause && pp), 1, "supply change inside pause");
            pv = int'(vdd_code);
         end
         if (int'(cpu_clk_sel) != pc) begin
            if (k_c < 0) k_c = k;
            check("R5", int'(clk_pause && pp), 1, "clock change inside pause");
            pc = int'(cpu_clk_sel);
         end
         if (done) begin
            k_done = k;
            check("R11", clk_pause, 0, "pause falls with done");
            check("R7", busy, 0, "busy low at done");
            break;
         end
         pp = clk_pause;
         if (poke >= 0 && k == 3) begin
            req_valid = 1'b1; req_level = 2'(poke);
         end
         if (poke >= 0 && k == 4) req_valid = 1'b0;
         if (slow_until > 0 && k == slow_until) vdd_settled = 1'b1;
         @(negedge clk);
         k++;
      end
      req_valid = 1'b0;
      vdd_settled = 1'b1;
   endtask

   initial begin
      int kd, kv, kc;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(vdd_code), 110, "reset supply code");
      check("R1", int'(cpu_clk_sel), 0, "reset clock select");
      check("R1", int'(bus_clk_div), 0, "reset bus divide");
      check("R1", int'(clk_pause), 0, "reset pause");
      check("R1", int'(busy), 0, "reset busy");
      check("R1", int'(done), 0, "reset done");
      check("R1", int'(cur_level), 0, "reset level");

      // up 0 -> 2: delta 20 codes, 40 cycles
      run_req(2, -1, 0, "R3", kd, kv, kc);
      check("R6", kd, 45, "up 0->2 completion cycle");
      check("R3", kv, 2, "up: supply change cycle");
      check("R3", kc, 44, "up: clock change after settle");
      check("R7", int'(cur_level), 2, "level after up");
      check("R2", int'(vdd_code), 130, "level 2 supply code");
      check("R2", int'(cpu_clk_sel), 2, "level 2 clock select");
      check("R2", int'(bus_clk_div), 1, "level 2 bus divide");
      @(negedge clk);
      check("R7", int'(done), 0, "done lasts one cycle");

      // down 2 -> 1: delta 10 codes, 20 cycles
      run_req(1, -1, 0, "R4", kd, kv, kc);
      check("R6", kd, 25, "down 2->1 completion cycle");
      check("R4", kc, 2, "down: clock change first");
      check("R4", kv, 3, "down: supply change after clock");
      check("R2", int'(vdd_code), 120, "level 1 supply code");
      check("R2", int'(cpu_clk_sel), 1, "level 1 clock select");
      check("R2", int'(bus_clk_div), 0, "level 1 bus divide");
      @(negedge clk);

      // same level
      run_req(1, -1, 0, "R9", kd, kv, kc);
      check("R9", kd, 1, "same level completes next edge");
      check("R9", kv, -1, "same level no supply change");
      @(negedge clk);

      // up 1 -> 2 with late settle indication
      run_req(2, -1, 32, "R6", kd, kv, kc);
      check("R6", kd, 35, "late settled stretches transition");
      check("R6", kc, 34, "clock waits for settled");
      @(negedge clk);

      // down 2 -> 0 with a request while busy
      run_req(0, 1, 0, "R8", kd, kv, kc);
      check("R8", kd, 45, "busy request does not disturb timing");
      check("R8", int'(cur_level), 0, "first target kept");
      check("R8", int'(vdd_code), 110, "first target supply");
      @(negedge clk);

      // out of range request
      tag = "R10";
      req_valid = 1'b1; req_level = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 6; i++) begin
         check("R10", int'(busy), 0, "no busy for level 3");
         check("R10", int'(done), 0, "no done for level 3");
         check("R10", int'(vdd_code), 110, "supply unchanged for level 3");
         @(negedge clk);
      end

      // up 0 -> 1
      run_req(1, -1, 0, "R2", kd, kv, kc);
      check("R6", kd, 25, "up 0->1 completion cycle");
      check("R2", int'(vdd_code), 120, "level 1 supply after up");
      @(negedge clk);

      over = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!over) begin
         over = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule